// File: doc/BRIEF.md
# Shadow Stack Page Permission Checker

This block sits next to a page-table walker or translation cache. It judges one memory access against the permission bits of the leaf page-table entry that translated it. It returns whether the access may proceed and, if it may not, which fault class the core must raise. A dedicated encoding marks shadow-stack pages: writable, not readable, not executable. Such a page accepts shadow-stack pushes and pops and plain loads. It turns away ordinary stores and cache-block maintenance operations with an access fault rather than a page fault. When shadow stacks are switched off at the current privilege, that same encoding is reserved and page-faults.

The verdict is computed combinationally and captured in an output register, so it appears one clock after the request. A two-state response machine runs the strobe. `ST_IDLE` means no verdict is presented. A request moves it to `ST_HOLD`, and it stays there while requests keep arriving every cycle. An edge without a request returns it to `ST_IDLE`. Page walking, translation storage and accessed/dirty updates belong to the surrounding logic.

Top module: `ssp_perm_checker`

## Requirements
- R1: A request sampled at a rising edge with `req_valid` high yields `rsp_valid` high for the following cycle. An edge with `req_valid` low yields `rsp_valid` low for the following cycle.
- R2: Fault codes are 2'b00 none, 2'b01 load page fault, 2'b10 store page fault and 2'b11 store/AMO access fault. `rsp_allow` is high exactly when the code is 2'b00 during `rsp_valid`. While `rsp_valid` is low, `rsp_allow` is 0 and the code is 2'b00.
- R3: A PTE with V=0, or with R=0, W=1 and X=1, faults. A regular load (kind 0) gets 2'b01. Every other kind gets 2'b10.
- R4: With `ss_en` low, R=0/W=1/X=0 on a valid PTE is treated as in R3.
- R5: With `ss_en` high, a valid R=0/W=1/X=0 PTE is a shadow-stack page, and a regular load (kind 0) to it is allowed.
- R6: A regular store/AMO (kind 1) to a shadow-stack page gets 2'b11. Kinds 5 to 7 are handled as regular stores everywhere.
- R7: Shadow-stack loads (kind 2) and shadow-stack stores (kind 3) to a shadow-stack page are allowed.
- R8: A cache-block operation (kind 4) to a shadow-stack page gets 2'b11 whatever `cbo_rd_ok` says.
- R9: A shadow-stack access (kind 2 or 3) to any other valid page gets 2'b11 when W=1 and 2'b10 when W=0.
- R10: On any other valid page, a regular load is allowed when R=1 and otherwise gets 2'b01. A regular store is allowed when W=1 and otherwise gets 2'b10.
- R11: On any other valid page, a cache-block operation is allowed when `cbo_rd_ok` is high. Otherwise it is allowed when W=1 and gets 2'b10 when W=0.
- R12: While `rst_n` is low, `rsp_valid` and `rsp_allow` are 0 and the fault code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| pte_v | input | 1 | Leaf PTE valid bit |
| pte_r | input | 1 | Leaf PTE read bit |
| pte_w | input | 1 | Leaf PTE write bit |
| pte_x | input | 1 | Leaf PTE execute bit |
| acc_kind | input | 3 | 0 load, 1 store/AMO, 2 shadow-stack load, 3 shadow-stack store, 4 cache-block op, 5-7 as store |
| cbo_rd_ok | input | 1 | Cache-block op holds read permission |
| ss_en | input | 1 | Shadow stacks enabled at current privilege |
| rsp_valid | output | 1 | Verdict strobe, one cycle after the request |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 2 | Fault code |

## Verification
Every combination of the PTE bits, `cbo_rd_ok`, `ss_en` and the eight access kinds is swept once. This separates the shadow-stack page from the reserved encoding, from read-only pages and from read-write pages, and it tells access faults apart from page faults for each kind. Random back-to-back and gapped streams then show that the strobe follows the request timing through the `ST_IDLE`/`ST_HOLD` transitions. They also show that a stale verdict never lingers on an idle cycle. Directed cases fix the points where a single bit flips the answer: cache-block operations with and without read permission, and shadow-stack accesses to writable and read-only pages.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int KIND_W  = 3;
    localparam int FAULT_W = 2;

    localparam logic [KIND_W-1:0] ACC_LOAD     = 3'd0;
    localparam logic [KIND_W-1:0] ACC_STORE    = 3'd1;
    localparam logic [KIND_W-1:0] ACC_SS_LOAD  = 3'd2;
    localparam logic [KIND_W-1:0] ACC_SS_STORE = 3'd3;
    localparam logic [KIND_W-1:0] ACC_CBO      = 3'd4;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE     = 2'b00,
        FLT_LOAD_PF  = 2'b01,
        FLT_STORE_PF = 2'b10,
        FLT_STORE_AF = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        PG_BAD    = 2'd0,
        PG_SHADOW = 2'd1,
        PG_NORMAL = 2'd2
    } page_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic   allow;
        fault_e fault;
    } verdict_t;

endpackage

// File: rtl/ssp_page_class.sv
module ssp_page_class
    import ssp_pkg::*;
(
    input  logic        v,
    input  logic        r,
    input  logic        w,
    input  logic        x,
    input  logic        ss_en,
    output page_class_e cls
);
    always_comb begin
        if (!v) begin
            cls = PG_BAD;
        end else if (w && !r) begin
            // write-only encodings: shadow stack page or reserved
            cls = (!x && ss_en) ? PG_SHADOW : PG_BAD;
        end else begin
            cls = PG_NORMAL;
        end
    end
endmodule

// File: rtl/ssp_perm_decide.sv
module ssp_perm_decide
    import ssp_pkg::*;
(
    input  page_class_e       cls,
    input  logic              r,
    input  logic              w,
    input  logic [KIND_W-1:0] kind,
    input  logic              cbo_rd_ok,
    output verdict_t          verdict
);
    fault_e flt;

    always_comb begin
        flt = FLT_NONE;
        unique case (cls)
            PG_BAD: begin
                flt = (kind == ACC_LOAD) ? FLT_LOAD_PF : FLT_STORE_PF;
            end
            PG_SHADOW: begin
                case (kind)
                    ACC_LOAD, ACC_SS_LOAD, ACC_SS_STORE: flt = FLT_NONE;
                    default:                             flt = FLT_STORE_AF;
                endcase
            end
            PG_NORMAL: begin
                case (kind)
                    ACC_LOAD:                 flt = r ? FLT_NONE : FLT_LOAD_PF;
                    ACC_SS_LOAD, ACC_SS_STORE: flt = w ? FLT_STORE_AF : FLT_STORE_PF;
                    ACC_CBO:                  flt = (cbo_rd_ok || w) ? FLT_NONE : FLT_STORE_PF;
                    default:                  flt = w ? FLT_NONE : FLT_STORE_PF;
                endcase
            end
            default: flt = FLT_STORE_PF;
        endcase
        verdict.fault = flt;
        verdict.allow = (flt == FLT_NONE);
    end
endmodule

// File: rtl/ssp_perm_checker.sv
module ssp_perm_checker
    import ssp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               pte_v,
    input  logic               pte_r,
    input  logic               pte_w,
    input  logic               pte_x,
    input  logic [KIND_W-1:0]  acc_kind,
    input  logic               cbo_rd_ok,
    input  logic               ss_en,
    output logic               rsp_valid,
    output logic               rsp_allow,
    output logic [FAULT_W-1:0] rsp_fault
);
    page_class_e cls;
    verdict_t    verdict_d;
    verdict_t    verdict_q;
    rsp_state_e  state_q;
    rsp_state_e  state_d;

    ssp_page_class u_class (
        .v     (pte_v),
        .r     (pte_r),
        .w     (pte_w),
        .x     (pte_x),
        .ss_en (ss_en),
        .cls   (cls)
    );

    ssp_perm_decide u_decide (
        .cls       (cls),
        .r         (pte_r),
        .w         (pte_w),
        .kind      (acc_kind),
        .cbo_rd_ok (cbo_rd_ok),
        .verdict   (verdict_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = req_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= '0;
        end else begin
            state_q   <= state_d;
            verdict_q <= req_valid ? verdict_d : '0;
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_HOLD);
        rsp_allow = verdict_q.allow;
        rsp_fault = verdict_q.fault;
    end
endmodule

// File: rtl/ssp_perm_checker_sva.sv
module ssp_perm_checker_sva
    import ssp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               pte_v,
    input logic               pte_r,
    input logic               pte_w,
    input logic               pte_x,
    input logic [KIND_W-1:0]  acc_kind,
    input logic               cbo_rd_ok,
    input logic               ss_en,
    input logic               rsp_valid,
    input logic               rsp_allow,
    input logic [FAULT_W-1:0] rsp_fault
);
    assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_strobe_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_allow && rsp_fault == 2'b00));

    assert_allow_no_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_allow == (rsp_fault == 2'b00)));

    assert_ss_page_store_af_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte_v && pte_w && !pte_r && !pte_x && ss_en && acc_kind == ACC_STORE)
        |=> rsp_fault == 2'b11);

    assert_ss_page_cbo_af_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte_v && pte_w && !pte_r && !pte_x && ss_en && acc_kind == ACC_CBO)
        |=> rsp_fault == 2'b11);

    assert_invalid_load_pf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pte_v && acc_kind == ACC_LOAD) |=> rsp_fault == 2'b01);

    assert_cbo_read_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte_v && pte_r && acc_kind == ACC_CBO && cbo_rd_ok) |=> rsp_allow);
endmodule

bind ssp_perm_checker ssp_perm_checker_sva u_sva (.*);

// File: tb/ssp_perm_checker_test.sv
module ssp_perm_checker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       pte_v = 1'b0, pte_r = 1'b0, pte_w = 1'b0, pte_x = 1'b0;
    logic [2:0] acc_kind = 3'd0;
    logic       cbo_rd_ok = 1'b0, ss_en = 1'b0;
    logic       rsp_valid, rsp_allow;
    logic [1:0] rsp_fault;

    int compared = 0;
    int mismatched = 0;
    logic       pend = 1'b0;
    logic [2:0] pend_exp = 3'd0;
    string      pend_tag = "";

    always #10 clk = ~clk;

    ssp_perm_checker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .pte_v(pte_v), .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x),
        .acc_kind(acc_kind), .cbo_rd_ok(cbo_rd_ok), .ss_en(ss_en),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault)
    );

    // {allow, fault} from the requirements
    function automatic logic [2:0] model(input logic v, r, w, x, input logic [2:0] k,
                                         input logic cbo, ss);
        logic [1:0] f;
        logic bad, shadow;
        bad    = !v || (!r && w && x) || (!r && w && !x && !ss);
        shadow = v && !r && w && !x && ss;
        if (bad)                      f = (k == 3'd0) ? 2'b01 : 2'b10;
        else if (shadow) begin
            if (k == 3'd0 || k == 3'd2 || k == 3'd3) f = 2'b00;
            else                                     f = 2'b11;
        end
        else if (k == 3'd2 || k == 3'd3) f = w ? 2'b11 : 2'b10;
        else if (k == 3'd0)           f = r ? 2'b00 : 2'b01;
        else if (k == 3'd4)           f = (cbo || w) ? 2'b00 : 2'b10;
        else                          f = w ? 2'b00 : 2'b10;
        return {(f == 2'b00), f};
    endfunction

    function automatic string tag_of(input logic v, r, w, x, input logic [2:0] k, input logic ss);
        if (!v || (!r && w && x)) return "R3";
        if (!r && w && !ss)       return "R4";
        if (!r && w) begin
            if (k == 3'd0) return "R5";
            if (k == 3'd2 || k == 3'd3) return "R7";
            if (k == 3'd4) return "R8";
            return "R6";
        end
        if (k == 3'd2 || k == 3'd3) return "R9";
        if (k == 3'd4) return "R11";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual valid/allow/fault=%b expected %b", tag, act, exp);
        end
    endtask

    // At a negedge: check the response to the previous cycle, then drive the next cycle.
    task automatic step(input logic vld, input logic v, r, w, x, input logic [2:0] k,
                        input logic cbo, ss);
        @(negedge clk);
        if (pend) check({pend_tag, "/R1/R2"}, {rsp_valid, rsp_allow, rsp_fault}, {1'b1, pend_exp});
        else      check("R1/R2 idle", {rsp_valid, rsp_allow, rsp_fault}, 4'b0000);
        req_valid = vld; pte_v = v; pte_r = r; pte_w = w; pte_x = x;
        acc_kind = k; cbo_rd_ok = cbo; ss_en = ss;
        pend = vld;
        pend_exp = model(v, r, w, x, k, cbo, ss);
        pend_tag = tag_of(v, r, w, x, k, ss);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R12 reset", {rsp_valid, rsp_allow, rsp_fault}, 4'b0000);
        rst_n = 1'b1;

        // directed corners
        step(1, 1,0,1,0, 3'd1, 0, 1);  // R6 store to shadow page -> 11
        step(1, 1,0,1,0, 3'd4, 1, 1);  // R8 cbo with read ok still 11
        step(1, 1,0,1,0, 3'd3, 0, 1);  // R7 allowed
        step(1, 1,0,1,0, 3'd0, 0, 1);  // R5 allowed
        step(1, 1,0,1,0, 3'd3, 0, 0);  // R4 reserved -> 10
        step(1, 1,1,0,0, 3'd3, 0, 1);  // R9 read-only -> 10
        step(1, 1,1,1,0, 3'd2, 0, 1);  // R9 writable -> 11
        step(1, 1,0,0,1, 3'd4, 0, 1);  // R11 no read, no write -> 10
        step(1, 1,0,0,1, 3'd4, 1, 1);  // R11 read ok -> allowed
        step(1, 0,1,1,1, 3'd0, 0, 1);  // R3 invalid load -> 01
        step(0, 0,0,0,0, 3'd0, 0, 0);
        step(0, 0,0,0,0, 3'd0, 0, 0);

        // exhaustive sweep, back to back
        for (int i = 0; i < 512; i++) begin
            step(1, i[0], i[1], i[2], i[3], i[6:4], i[7], i[8]);
        end

        // random mix with gaps
        for (int n = 0; n < 3000; n++) begin
            rv = $urandom;
            step(rv[0] | rv[1], rv[2], rv[3], rv[4], rv[5], rv[8:6], rv[9], rv[10]);
        end
        step(0, 0,0,0,0, 3'd0, 0, 0);
        step(0, 0,0,0,0, 3'd0, 0, 0);

        // reset in the middle of a stream
        step(1, 1,1,1,0, 3'd1, 0, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset mid-stream", {rsp_valid, rsp_allow, rsp_fault}, 4'b0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule